// File: doc/BRIEF.md
# Watermarked Byte FIFO with 1/2/4-Byte Host Access

This block is a byte-wide data buffer between a register-mapped host port and a serial bus engine. The host reaches the buffer through one data address. Each access moves one, two or four bytes, packed into byte lanes of a 32-bit word. The engine side moves a single byte per cycle in either direction. Outgoing data is pushed by the host and popped by the engine. Incoming data is pushed by the engine and popped by the host.

Status outputs report the current occupancy and the fixed depth. Two flags compare the occupancy against a programmable high and low threshold. Host overrun and host underrun or malformed accesses latch sticky error bits. A single error-clear strobe empties the buffer and clears both error bits, so that software can restart after a failed transfer. The host may also pop bytes it does not need, to drain stale data.

Top module: `wmark_byte_fifo`

## Requirements
- R1: After reset the occupancy is 0, both error bits are 0, the high threshold is 15 and the low threshold is 0. The low-water flag is therefore 1, the high-water flag is 0, and `hostRData` is 0.
- R2: `extStatus[31:24]` always equals the parameter `DEPTH`. `statusWord[7:0]` carries the occupancy, which changes on the clock edge that follows the access causing it.
- R3: A host write (`hostValid`=1, `hostWrite`=1) with a `hostSize` of 1, 2 or 4 stores that many bytes. Byte i comes from `hostWData[8i+7:8i]`, and the bytes are stored in ascending lane order.
- R4: A host read with a `hostSize` of 1, 2 or 4 removes bytes from the head in arrival order, placing the k-th removed byte in lane k of `hostRData`. Unused lanes read 0. `hostRData` is registered and valid from the edge after the access until the next read.
- R5: A `hostSize` of 0, 3, 5, 6 or 7 moves no data and leaves `hostRData` unchanged. It sets the sticky access-error bit `statusWord[28]`.
- R6: A host write larger than the free space stores only as many bytes as fit, starting at lane 0, and drops the rest. It also sets the sticky overrun bit `statusWord[29]`. The occupancy never exceeds `DEPTH`.
- R7: A host read larger than the occupancy returns every stored byte in the low lanes and 0 in the lanes beyond them. It leaves the buffer empty and sets `statusWord[28]`.
- R8: The engine pushes `engPushData` with `engPush` and pops the head byte, shown on `engPopData`, with `engPop`. A push is accepted (`engPushAck`) only when the buffer is not full. A pop is accepted (`engPopAck`) only when the buffer is not empty. Neither is accepted in a cycle with `hostValid` or `errClear` high. A push and a pop may be accepted in the same cycle.
- R9: `wmWrite` loads the high threshold from `wmWData[15:12]` and the low threshold from `wmWData[7:4]`. `extStatus[9]` is 1 when occupancy is at or above the high threshold. `extStatus[8]` is 1 when occupancy is at or below the low threshold.
- R10: `errClear` empties the buffer and clears both error bits on the next edge. Any host or engine request in the same cycle is ignored. The thresholds are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access to the data address this cycle |
| hostWrite | input | 1 | 1 = push, 0 = pop |
| hostSize | input | 3 | Bytes in the access (1, 2 or 4 legal) |
| hostWData | input | 32 | Write bytes, lane 0 in bits 7:0 |
| hostRData | output | 32 | Read bytes, registered |
| engPush | input | 1 | Engine offers a byte |
| engPushData | input | 8 | Byte offered by the engine |
| engPushAck | output | 1 | Engine byte accepted this cycle |
| engPop | input | 1 | Engine takes the head byte |
| engPopData | output | 8 | Head byte |
| engPopAck | output | 1 | Head byte removed this cycle |
| wmWrite | input | 1 | Load thresholds |
| wmWData | input | 32 | Thresholds: high in 15:12, low in 7:4 |
| errClear | input | 1 | Flush buffer and clear error bits |
| statusWord | output | 32 | Overrun 29, access error 28, occupancy 7:0 |
| extStatus | output | 32 | Depth 31:24, high flag 9, low flag 8 |

## Verification
The hardest state to reach is a host access that straddles the boundary: a 4-byte write with only one to three free slots, or a 4-byte read with fewer than four bytes stored. This must happen while the storage pointers sit near the wrap point, so that the lane mapping and the wrap are exercised together. The stimulus first cycles many bytes through with mixed host and engine traffic to move the pointers around the ring. It then fills the buffer to within a byte or two of full, or drains it to a single byte, before issuing the oversized access. A long run of random sizes, including illegal ones, interleaved with engine requests and occasional flushes, revisits these edges at many pointer offsets.

// File: rtl/wmark_byte_fifo_pkg.sv
package wmark_byte_fifo_pkg;

  localparam int LANES = 4;

  typedef struct packed {
    logic       flush;
    logic [2:0] pushCnt;
    logic [2:0] popCnt;
    logic       pushFromEng;
    logic       hostRd;
  } fifoStrobes_t;

endpackage

// File: rtl/wmark_byte_fifo_ctrl.sv
module wmark_byte_fifo_ctrl
  import wmark_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [2:0]         hostSize,
  input  logic               engPush,
  input  logic               engPop,
  input  logic               wmWrite,
  input  logic [31:0]        wmWData,
  input  logic               errClear,
  input  logic [CNT_W-1:0]   count,
  output fifoStrobes_t       st,
  output logic               engPushAck,
  output logic               engPopAck,
  output logic               overrunErr,
  output logic               accessErr,
  output logic               hiFlag,
  output logic               loFlag
);

  logic [CNT_W:0] freeSp;
  logic           sizeOk;
  logic           setOvr;
  logic           setAcc;
  logic [3:0]     wmHi;
  logic [3:0]     wmLo;

  assign freeSp = (CNT_W + 1)'(DEPTH) - {1'b0, count};
  assign sizeOk = (hostSize == 3'd1) || (hostSize == 3'd2) || (hostSize == 3'd4);

  always_comb begin
    st         = '0;
    st.flush   = errClear;
    engPushAck = 1'b0;
    engPopAck  = 1'b0;
    setOvr     = 1'b0;
    setAcc     = 1'b0;
    if (!errClear) begin
      if (hostValid) begin
        if (!sizeOk) begin
          setAcc = 1'b1;
        end else if (hostWrite) begin
          if (int'(hostSize) > int'(freeSp)) begin
            st.pushCnt = 3'(freeSp);
            setOvr     = 1'b1;
          end else begin
            st.pushCnt = hostSize;
          end
        end else begin
          st.hostRd = 1'b1;
          if (int'(hostSize) > int'(count)) begin
            st.popCnt = 3'(count);
            setAcc    = 1'b1;
          end else begin
            st.popCnt = hostSize;
          end
        end
      end else begin
        engPushAck     = engPush && (int'(count) < DEPTH);
        engPopAck      = engPop && (count != '0);
        st.pushCnt     = {2'b00, engPushAck};
        st.popCnt      = {2'b00, engPopAck};
        st.pushFromEng = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunErr <= 1'b0;
      accessErr  <= 1'b0;
    end else if (errClear) begin
      overrunErr <= 1'b0;
      accessErr  <= 1'b0;
    end else begin
      if (setOvr) overrunErr <= 1'b1;
      if (setAcc) accessErr  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wmHi <= 4'hF;
      wmLo <= 4'h0;
    end else if (wmWrite) begin
      wmHi <= wmWData[15:12];
      wmLo <= wmWData[7:4];
    end
  end

  assign hiFlag = int'(count) >= int'(wmHi);
  assign loFlag = int'(count) <= int'(wmLo);

endmodule

// File: rtl/wmark_byte_fifo_dpath.sv
module wmark_byte_fifo_dpath
  import wmark_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     st,
  input  logic [31:0]      hostWData,
  input  logic [7:0]       engPushData,
  output logic [CNT_W-1:0] count,
  output logic [31:0]      hostRData,
  output logic [7:0]       engPopData
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [31:0]      rdNext;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_rdLane
      assign rdNext[8*g +: 8] = (g < int'(st.popCnt)) ? mem[rdPtr + PTR_W'(g)] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(st.pushCnt)) begin
        mem[wrPtr + PTR_W'(i)] <= st.pushFromEng ? engPushData : hostWData[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      hostRData <= '0;
    end else if (st.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(st.pushCnt);
      rdPtr <= rdPtr + PTR_W'(st.popCnt);
      count <= count + CNT_W'(st.pushCnt) - CNT_W'(st.popCnt);
      if (st.hostRd) hostRData <= rdNext;
    end
  end

  assign engPopData = mem[rdPtr];

endmodule

// File: rtl/wmark_byte_fifo.sv
module wmark_byte_fifo
  import wmark_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic [2:0]  hostSize,
  input  logic [31:0] hostWData,
  output logic [31:0] hostRData,
  input  logic        engPush,
  input  logic [7:0]  engPushData,
  output logic        engPushAck,
  input  logic        engPop,
  output logic [7:0]  engPopData,
  output logic        engPopAck,
  input  logic        wmWrite,
  input  logic [31:0] wmWData,
  input  logic        errClear,
  output logic [31:0] statusWord,
  output logic [31:0] extStatus
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobes_t     st;
  logic [CNT_W-1:0] occCount;
  logic             overrunErr;
  logic             accessErr;
  logic             hiFlag;
  logic             loFlag;

  wmark_byte_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostValid  (hostValid),
    .hostWrite  (hostWrite),
    .hostSize   (hostSize),
    .engPush    (engPush),
    .engPop     (engPop),
    .wmWrite    (wmWrite),
    .wmWData    (wmWData),
    .errClear   (errClear),
    .count      (occCount),
    .st         (st),
    .engPushAck (engPushAck),
    .engPopAck  (engPopAck),
    .overrunErr (overrunErr),
    .accessErr  (accessErr),
    .hiFlag     (hiFlag),
    .loFlag     (loFlag)
  );

  wmark_byte_fifo_dpath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .hostWData   (hostWData),
    .engPushData (engPushData),
    .count       (occCount),
    .hostRData   (hostRData),
    .engPopData  (engPopData)
  );

  assign statusWord = {2'b00, overrunErr, accessErr, 20'h0, 8'(occCount)};
  assign extStatus  = {8'(DEPTH), 14'h0, hiFlag, loFlag, 8'h00};

endmodule

// File: rtl/wmark_byte_fifo_chk.sv
module wmark_byte_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostValid,
  input logic [2:0]  hostSize,
  input logic        engPush,
  input logic        engPop,
  input logic        errClear,
  input logic        engPushAck,
  input logic        engPopAck,
  input logic [31:0] statusWord
);

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(statusWord[7:0]) <= DEPTH);

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    errClear |=> (statusWord[7:0] == 8'h00) && (statusWord[29:28] == 2'b00));

  assert_bad_size_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !errClear && hostSize == 3'd3) |=> statusWord[28]);

  assert_sticky_ovr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[29] && !errClear) |=> statusWord[29]);

  assert_eng_holdoff_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid || errClear) |-> (!engPushAck && !engPopAck));

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rstN)
    engPopAck |-> (statusWord[7:0] != 8'h00));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!hostValid && !engPush && !engPop && !errClear) |=> $stable(statusWord[7:0]));

endmodule

bind wmark_byte_fifo wmark_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostValid  (hostValid),
  .hostSize   (hostSize),
  .engPush    (engPush),
  .engPop     (engPop),
  .errClear   (errClear),
  .engPushAck (engPushAck),
  .engPopAck  (engPopAck),
  .statusWord (statusWord)
);

// File: tb/tb_wmark_byte_fifo.sv
module tb_wmark_byte_fifo;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [2:0]  hostSize = 3'd0;
  logic [31:0] hostWData = '0;
  logic [31:0] hostRData;
  logic        engPush = 1'b0;
  logic [7:0]  engPushData = '0;
  logic        engPushAck;
  logic        engPop = 1'b0;
  logic [7:0]  engPopData;
  logic        engPopAck;
  logic        wmWrite = 1'b0;
  logic [31:0] wmWData = '0;
  logic        errClear = 1'b0;
  logic [31:0] statusWord;
  logic [31:0] extStatus;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0]  mq[$];
  bit          mOvr = 0;
  bit          mAcc = 0;
  int          mHi = 15;
  int          mLo = 0;
  logic [31:0] mR = '0;

  always #4 clk = ~clk;

  wmark_byte_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostWData(hostWData), .hostRData(hostRData),
    .engPush(engPush), .engPushData(engPushData), .engPushAck(engPushAck),
    .engPop(engPop), .engPopData(engPopData), .engPopAck(engPopAck),
    .wmWrite(wmWrite), .wmWData(wmWData), .errClear(errClear),
    .statusWord(statusWord), .extStatus(extStatus)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int n;
    n = mq.size();
    check(int'(statusWord[7:0]) == n, "R2/R3 occupancy", 32'(statusWord[7:0]), 32'(n));
    check(extStatus[31:24] == 8'(DEPTH), "R2 depth field", 32'(extStatus[31:24]), 32'(DEPTH));
    check(statusWord[29] == mOvr, "R6 overrun bit", 32'(statusWord[29]), 32'(mOvr));
    check(statusWord[28] == mAcc, "R5/R7 access error bit", 32'(statusWord[28]), 32'(mAcc));
    check(extStatus[9] == (n >= mHi), "R9 high flag", 32'(extStatus[9]), 32'(n >= mHi));
    check(extStatus[8] == (n <= mLo), "R9 low flag", 32'(extStatus[8]), 32'(n <= mLo));
    check(hostRData === mR, "R4 read data", hostRData, mR);
    if (n > 0) check(engPopData === mq[0], "R8 head byte", 32'(engPopData), 32'(mq[0]));
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic cyc();
    bit eP;
    bit eR;
    logic [31:0] r;
    #1;
    eP = engPush && !hostValid && !errClear && (mq.size() < DEPTH);
    eR = engPop && !hostValid && !errClear && (mq.size() > 0);
    check(engPushAck === eP, "R8 push ack", 32'(engPushAck), 32'(eP));
    check(engPopAck === eR, "R8 pop ack", 32'(engPopAck), 32'(eR));
    if (wmWrite) begin
      mHi = int'(wmWData[15:12]);
      mLo = int'(wmWData[7:4]);
    end
    if (errClear) begin
      mq.delete();
      mOvr = 0;
      mAcc = 0;
    end else if (hostValid) begin
      if (!(hostSize == 3'd1 || hostSize == 3'd2 || hostSize == 3'd4)) begin
        mAcc = 1;
      end else if (hostWrite) begin
        for (int i = 0; i < int'(hostSize); i++) begin
          if (mq.size() < DEPTH) mq.push_back(hostWData[8*i +: 8]);
          else mOvr = 1;
        end
      end else begin
        r = '0;
        for (int i = 0; i < int'(hostSize); i++) begin
          if (mq.size() > 0) r[8*i +: 8] = mq.pop_front();
          else mAcc = 1;
        end
        mR = r;
      end
    end else begin
      if (eR) void'(mq.pop_front());
      if (eP) mq.push_back(engPushData);
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
    hostValid = 1'b0;
    engPush   = 1'b0;
    engPop    = 1'b0;
    errClear  = 1'b0;
    wmWrite   = 1'b0;
  endtask

  task automatic hostW(input int sz, input logic [31:0] d);
    hostValid = 1'b1; hostWrite = 1'b1; hostSize = 3'(sz); hostWData = d;
    cyc();
  endtask

  task automatic hostR(input int sz);
    hostValid = 1'b1; hostWrite = 1'b0; hostSize = 3'(sz);
    cyc();
  endtask

  task automatic eng(input bit p, input bit q, input logic [7:0] d);
    engPush = p; engPop = q; engPushData = d;
    cyc();
  endtask

  task automatic setWm(input int hi, input int lo);
    wmWrite = 1'b1;
    wmWData = {16'h0, 4'(hi), 4'h0, 4'(lo), 4'h0};
    cyc();
  endtask

  task automatic clr();
    errClear = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(statusWord == 32'h0, "R1 status after reset", statusWord, 32'h0);
    check(extStatus == {8'(DEPTH), 14'h0, 2'b01, 8'h0}, "R1 ext status after reset",
          extStatus, {8'(DEPTH), 14'h0, 2'b01, 8'h0});
    check(hostRData == 32'h0, "R1 read data after reset", hostRData, 32'h0);
    rstN = 1'b1;
    cyc();

    // R3/R4: each legal size, lane order
    hostW(4, 32'h44332211);
    hostW(2, 32'hAAAA6655);
    hostW(1, 32'hBBBBBB77);
    hostR(1);
    check(hostRData == 32'h00000011, "R4 one-byte read", hostRData, 32'h00000011);
    hostR(2);
    check(hostRData == 32'h00003322, "R4 two-byte read", hostRData, 32'h00003322);
    hostR(4);
    check(hostRData == 32'h77665544, "R4 four-byte read", hostRData, 32'h77665544);

    // R5: illegal sizes
    hostW(3, 32'hDEADBEEF);
    check(statusWord[28] == 1'b1, "R5 size 3 sets access error", 32'(statusWord[28]), 32'h1);
    hostR(0);
    hostR(6);
    // R10: flush clears error
    hostW(2, 32'h0000CAFE);
    clr();
    check(statusWord == 32'h0, "R10 flush empties and clears", statusWord, 32'h0);

    // move pointers near wrap, then R6 overrun
    for (int k = 0; k < 13; k++) eng(1'b1, 1'b0, 8'(k + 8'h30));
    for (int k = 0; k < 13; k++) eng(1'b0, 1'b1, 8'h00);
    for (int k = 0; k < 3; k++) hostW(4, 32'h03020100 + 32'(k) * 32'h04040404);
    hostW(2, 32'h00000D0C);
    hostW(4, 32'h13121110);
    check(statusWord[7:0] == 8'(DEPTH), "R6 full after overrun", 32'(statusWord[7:0]), 32'(DEPTH));
    check(statusWord[29] == 1'b1, "R6 overrun latched", 32'(statusWord[29]), 32'h1);
    eng(1'b1, 1'b1, 8'h99);   // R8 full: pop accepted, push refused

    // R7: underrun
    for (int k = 0; k < 3; k++) hostR(4);
    hostR(4);
    check(statusWord[28] == 1'b1, "R7 underrun latched", 32'(statusWord[28]), 32'h1);
    hostR(2);
    check(hostRData == 32'h0, "R7 empty read returns zero", hostRData, 32'h0);

    // R9: watermarks
    clr();
    setWm(5, 2);
    for (int k = 0; k < 6; k++) eng(1'b1, 1'b0, 8'(k));
    check(extStatus[9:8] == 2'b10, "R9 high flag at threshold", 32'(extStatus[9:8]), 32'h2);
    // R8: host access holds off engine
    hostValid = 1'b1; hostWrite = 1'b0; hostSize = 3'd1; engPush = 1'b1; engPop = 1'b1;
    cyc();
    // R10: flush overrides host write
    errClear = 1'b1; hostValid = 1'b1; hostWrite = 1'b1; hostSize = 3'd4;
    cyc();
    check(statusWord[7:0] == 8'h0, "R10 flush wins over write", 32'(statusWord[7:0]), 32'h0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 35) begin
        hostValid = 1'b1;
        hostWrite = $urandom_range(0, 1) == 1;
        hostSize  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7))
                                                : 3'(1 << $urandom_range(0, 2));
        hostWData = $urandom();
      end
      engPush     = $urandom_range(0, 2) == 0;
      engPop      = $urandom_range(0, 2) == 0;
      engPushData = 8'($urandom());
      if (sel == 99) errClear = 1'b1;
      if (sel == 98) begin
        wmWrite = 1'b1;
        wmWData = $urandom();
      end
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule